// File: doc/BRIEF.md
# Multilevel Thermometer-Code March Controller

This block is a built-in self-test sequencer for a memory whose cells each hold one of six signal levels. Each level is stored as a five-digit thermometer code, where level k has its k lowest digits set. After a start pulse the controller fills the whole array with the lowest code. It then makes five passes that raise every cell by one level. Each of these passes reads the code a cell should hold and writes the next code back to the same address. A last pass reads the top code from every cell. That gives twelve memory operations per cell.

The controller drives a plain synchronous memory port with address, write data, write enable, read enable and read data. It compares every returned word against the code it expects. It keeps a sticky fail flag together with the address, expected code and observed code of the earliest mismatch. A single-cycle done pulse ends the run.

Top module: `mtm_march_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, busy, done, fail, write enable and read enable are all low.
- R2: A start pulse seen while idle starts the fill pass: one write per cycle of code 00000 to addresses 0, 1, ... N-1, in ascending order.
- R3: Passes 1 to 5 visit addresses in ascending order. For each address, pass e issues a read, and in the next cycle a write to the same address of code e. Code k has its k least significant bits set: 00001, 00011, 00111, 01111, 11111.
- R4: Read data is taken in the cycle after read enable. The paired write is issued in that same cycle, never together with a read.
- R5: The final pass reads each address in ascending order, one read every two cycles, and expects 11111.
- R6: done is high for exactly one cycle, 13N+1 cycles after the clock edge that accepted start. busy falls in the following cycle.
- R7: A read word that differs from its expected code sets fail. fail stays set until the next start. The address, expected code and observed code of the first mismatch are kept, and later mismatches do not replace them.
- R8: A start pulse while a test is running has no effect on the operation sequence or on the done timing.
- R9: An accepted start clears fail, so a clean run after a failing one ends with fail low.
- R10: Read and write enable are never high together, and every issued address is below N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a test when idle |
| mem_addr_o | output | $clog2(DEPTH) | Memory address |
| mem_wdata_o | output | LEVELS-1 | Write data (thermometer code) |
| mem_we_o | output | 1 | Write enable |
| mem_re_o | output | 1 | Read enable |
| mem_rdata_i | input | LEVELS-1 | Read data, valid in the cycle after read enable |
| busy_o | output | 1 | A test is in progress |
| done_o | output | 1 | One-cycle end-of-test pulse |
| fail_o | output | 1 | Sticky mismatch flag |
| fail_addr_o | output | $clog2(DEPTH) | Address of the first mismatch |
| fail_exp_o | output | LEVELS-1 | Expected code at the first mismatch |
| fail_obs_o | output | LEVELS-1 | Observed code at the first mismatch |

## Verification
The assertions assume that the memory returns read data exactly one cycle after read enable and holds it for that cycle. They also assume that start is a synchronous level sampled on the clock. The bench memory has a registered read port with that latency and drives start only between clock edges. The injected stuck-at-one and stuck-at-zero masks change only the stored values, never the port timing. Data mismatches can therefore occur, but the handshake the checks rely on stays intact.

// File: rtl/mtm_pkg.sv
package mtm_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FILL,
      ST_RD,
      ST_WR,
      ST_FRD,
      ST_FCHK,
      ST_DONE
   } mtm_state_e;

endpackage

// File: rtl/mtm_addr_walker.sv
module mtm_addr_walker #(
   parameter int DEPTH = 16,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_i,
   input  logic          step_i,
   output logic [AW-1:0] addr_o,
   output logic          last_o
);

   localparam logic [AW-1:0] LastAddr = AW'(DEPTH - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      addr_o <= '0;
      else if (clr_i)  addr_o <= '0;
      else if (step_i) addr_o <= addr_o + 1'b1;
   end

   assign last_o = (addr_o == LastAddr);

   a_r10_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      addr_o <= LastAddr);

   a_r3_no_step_past_end: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !clr_i && last_o) |=> addr_o == '0);

endmodule

// File: rtl/mtm_code_gen.sv
module mtm_code_gen #(
   parameter int CW = 5,
   parameter int EW = $clog2(CW + 2)
) (
   input  logic [EW-1:0] elem_i,
   output logic [CW-1:0] rd_code_o,
   output logic [CW-1:0] wr_code_o
);

   // Pass e expects level e-1 and writes level e; digit i of level k is set when k > i.
   for (genvar i = 0; i < CW; i++) begin : g_digit
      assign rd_code_o[i] = (elem_i > EW'(i + 1));
      assign wr_code_o[i] = (elem_i > EW'(i));
   end

endmodule

// File: rtl/mtm_mismatch_log.sv
module mtm_mismatch_log #(
   parameter int AW = 4,
   parameter int CW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_i,
   input  logic          chk_i,
   input  logic [AW-1:0] addr_i,
   input  logic [CW-1:0] exp_i,
   input  logic [CW-1:0] obs_i,
   output logic          fail_o,
   output logic [AW-1:0] fail_addr_o,
   output logic [CW-1:0] fail_exp_o,
   output logic [CW-1:0] fail_obs_o
);

   logic hit;
   assign hit = chk_i && (obs_i != exp_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fail_o      <= 1'b0;
         fail_addr_o <= '0;
         fail_exp_o  <= '0;
         fail_obs_o  <= '0;
      end else if (clr_i) begin
         fail_o      <= 1'b0;
         fail_addr_o <= '0;
         fail_exp_o  <= '0;
         fail_obs_o  <= '0;
      end else if (hit && !fail_o) begin
         fail_o      <= 1'b1;
         fail_addr_o <= addr_i;
         fail_exp_o  <= exp_i;
         fail_obs_o  <= obs_i;
      end
   end

   a_r7_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (fail_o && !clr_i) |=> fail_o);

   a_r7_first_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (fail_o && !clr_i) |=> ($stable(fail_addr_o) && $stable(fail_exp_o) && $stable(fail_obs_o)));

   a_r9_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> !fail_o);

endmodule

// File: rtl/mtm_march_ctrl.sv
module mtm_march_ctrl #(
   parameter int DEPTH  = 16,
   parameter int LEVELS = 6,
   parameter int AW     = $clog2(DEPTH),
   parameter int CW     = LEVELS - 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   output logic [AW-1:0] mem_addr_o,
   output logic [CW-1:0] mem_wdata_o,
   output logic          mem_we_o,
   output logic          mem_re_o,
   input  logic [CW-1:0] mem_rdata_i,
   output logic          busy_o,
   output logic          done_o,
   output logic          fail_o,
   output logic [AW-1:0] fail_addr_o,
   output logic [CW-1:0] fail_exp_o,
   output logic [CW-1:0] fail_obs_o
);
   import mtm_pkg::*;

   localparam int EW = $clog2(CW + 2);
   localparam logic [EW-1:0] LastRw  = EW'(CW);
   localparam logic [EW-1:0] FinElem = EW'(CW + 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("mtm_march_ctrl: DEPTH must be at least 2");
   end
   if (LEVELS < 2) begin : g_bad_levels
      $error("mtm_march_ctrl: LEVELS must be at least 2");
   end
   if (AW < 1) begin : g_bad_aw
      $error("mtm_march_ctrl: AW must be at least 1");
   end

   mtm_state_e      state, state_nx;
   logic [EW-1:0]   elem, elem_nx;
   logic            a_clr, a_step, a_last, accept;
   logic [CW-1:0]   rd_code, wr_code;
   logic            rd_pend;
   logic [CW-1:0]   exp_pend;
   logic [AW-1:0]   addr_pend;

   mtm_addr_walker #(.DEPTH(DEPTH), .AW(AW)) u_walk (
      .clk(clk), .rst_n(rst_n), .clr_i(a_clr), .step_i(a_step),
      .addr_o(mem_addr_o), .last_o(a_last));

   mtm_code_gen #(.CW(CW), .EW(EW)) u_code (
      .elem_i(elem), .rd_code_o(rd_code), .wr_code_o(wr_code));

   assign accept = (state == ST_IDLE) && start_i;

   always_comb begin
      state_nx = state;
      elem_nx  = elem;
      a_clr    = 1'b0;
      a_step   = 1'b0;
      mem_we_o = 1'b0;
      mem_re_o = 1'b0;
      unique case (state)
         ST_IDLE: if (start_i) begin
            state_nx = ST_FILL;
            elem_nx  = '0;
            a_clr    = 1'b1;
         end
         ST_FILL: begin
            mem_we_o = 1'b1;
            if (a_last) begin
               a_clr    = 1'b1;
               elem_nx  = EW'(1);
               state_nx = ST_RD;
            end else a_step = 1'b1;
         end
         ST_RD: begin
            mem_re_o = 1'b1;
            state_nx = ST_WR;
         end
         ST_WR: begin
            mem_we_o = 1'b1;
            if (a_last) begin
               a_clr = 1'b1;
               if (elem == LastRw) begin
                  elem_nx  = FinElem;
                  state_nx = ST_FRD;
               end else begin
                  elem_nx  = elem + 1'b1;
                  state_nx = ST_RD;
               end
            end else begin
               a_step   = 1'b1;
               state_nx = ST_RD;
            end
         end
         ST_FRD: begin
            mem_re_o = 1'b1;
            state_nx = ST_FCHK;
         end
         ST_FCHK: begin
            if (a_last) begin
               a_clr    = 1'b1;
               state_nx = ST_DONE;
            end else begin
               a_step   = 1'b1;
               state_nx = ST_FRD;
            end
         end
         ST_DONE: state_nx = ST_IDLE;
         default: state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         elem      <= '0;
         rd_pend   <= 1'b0;
         exp_pend  <= '0;
         addr_pend <= '0;
      end else begin
         state     <= state_nx;
         elem      <= elem_nx;
         rd_pend   <= mem_re_o;
         exp_pend  <= rd_code;
         addr_pend <= mem_addr_o;
      end
   end

   assign mem_wdata_o = wr_code;
   assign busy_o      = (state != ST_IDLE);
   assign done_o      = (state == ST_DONE);

   mtm_mismatch_log #(.AW(AW), .CW(CW)) u_log (
      .clk(clk), .rst_n(rst_n), .clr_i(accept), .chk_i(rd_pend),
      .addr_i(addr_pend), .exp_i(exp_pend), .obs_i(mem_rdata_i),
      .fail_o(fail_o), .fail_addr_o(fail_addr_o),
      .fail_exp_o(fail_exp_o), .fail_obs_o(fail_obs_o));

   a_r10_no_rw_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we_o && mem_re_o));

   a_r4_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we_o && $past(mem_re_o)) |-> mem_addr_o == $past(mem_addr_o));

   a_r3_wdata_thermo: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o |-> ((mem_wdata_o & (mem_wdata_o + 1'b1)) == '0));

   a_r6_done_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(rd_pend));

   a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> (!done_o && !busy_o));

   a_r8_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !done_o) |=> busy_o);

endmodule

// File: tb/mtm_march_ctrl_tb_top.sv
`timescale 1ns/1ps
module mtm_march_ctrl_tb_top;

   localparam int N  = 8;
   localparam int AW = 3;
   localparam int CW = 5;
   localparam int VW = 27;

   // fields: fault addr, stuck-1 mask, stuck-0 mask, exp fail, exp addr, exp code, obs code
   localparam logic [VW-1:0] VEC [5] = '{
      {3'd3, 5'b00100, 5'b00000, 1'b1, 3'd3, 5'b00000, 5'b00100},
      {3'd7, 5'b00000, 5'b10000, 1'b1, 3'd7, 5'b11111, 5'b01111},
      {3'd0, 5'b00000, 5'b00001, 1'b1, 3'd0, 5'b00001, 5'b00000},
      {3'd5, 5'b00000, 5'b00100, 1'b1, 3'd5, 5'b00111, 5'b00011},
      {3'd1, 5'b00000, 5'b00000, 1'b0, 3'd0, 5'b00000, 5'b00000}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [AW-1:0] addr;
   logic [CW-1:0] wdata, rdata;
   logic          we, re, busy, done, fail;
   logic [AW-1:0] f_addr;
   logic [CW-1:0] f_exp, f_obs;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   logic [CW-1:0] mem [N];
   logic [CW-1:0] sa1 [N];
   logic [CW-1:0] sa0 [N];

   always #2.5 clk = ~clk;

   mtm_march_ctrl #(.DEPTH(N), .LEVELS(CW + 1)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start),
      .mem_addr_o(addr), .mem_wdata_o(wdata), .mem_we_o(we), .mem_re_o(re),
      .mem_rdata_i(rdata), .busy_o(busy), .done_o(done), .fail_o(fail),
      .fail_addr_o(f_addr), .fail_exp_o(f_exp), .fail_obs_o(f_obs));

   always_ff @(posedge clk) begin
      if (we) mem[addr] <= (wdata | sa1[addr]) & ~sa0[addr];
      if (re) rdata <= (mem[addr] | sa1[addr]) & ~sa0[addr];
   end

   function automatic logic [CW-1:0] therm(input int k);
      return CW'((1 << k) - 1);
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic clear_faults();
      for (int a = 0; a < N; a++) begin
         sa1[a] = '0;
         sa0[a] = '0;
      end
   endtask

   // Expected port activity at step s: kind 0 none, 1 write, 2 read
   task automatic expect_step(input int s, output int kind, output int ea, output int ec);
      kind = 0; ea = 0; ec = 0;
      if (s < N) begin
         kind = 1; ea = s; ec = 0;
      end else if (s < 11 * N) begin
         int t = s - N;
         int e = t / (2 * N) + 1;
         int r = t % (2 * N);
         ea = r / 2;
         if (r % 2 == 0) kind = 2;
         else begin kind = 1; ec = int'(therm(e)); end
      end else if (s < 13 * N) begin
         int t = s - 11 * N;
         ea = t / 2;
         kind = (t % 2 == 0) ? 2 : 0;
      end
   endtask

   task automatic run(input int glitch, output int cycles, output int seq_err,
                      output string seq_msg);
      int kind, ea, ec, act_kind;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      cycles = 1;
      seq_err = 0;
      seq_msg = "";
      check(fail == 1'b0, "R9 fail cleared on start", int'(fail), 0);
      forever begin
         start = (cycles == glitch);
         expect_step(cycles - 1, kind, ea, ec);
         act_kind = (we && re) ? 3 : we ? 1 : re ? 2 : 0;
         if (act_kind != kind || (kind != 0 && int'(addr) != ea) ||
             (kind == 1 && int'(wdata) != ec)) begin
            if (seq_err == 0)
               seq_msg = $sformatf("step %0d kind=%0d addr=%0d data=%0h exp kind=%0d addr=%0d data=%0h",
                                   cycles - 1, act_kind, addr, wdata, kind, ea, ec);
            seq_err++;
         end
         if (done || cycles > 20 * N) break;
         @(negedge clk);
         cycles++;
      end
      start = 1'b0;
   endtask

   initial begin
      int cyc, serr;
      string smsg;
      logic [VW-1:0] v;
      clear_faults();
      rdata = '0;
      for (int a = 0; a < N; a++) mem[a] = '0;
      repeat (3) @(negedge clk);
      // R1: outputs idle during reset
      check(!busy && !done && !fail && !we && !re, "R1 reset state", {busy, done, fail, we, re}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy && !done && !fail && !we && !re, "R1 after reset", {busy, done, fail, we, re}, 0);

      // table of fault scenarios; the last one is clean after a failing run (R9)
      for (int i = 0; i < 5; i++) begin
         v = VEC[i];
         clear_faults();
         sa1[v[26:24]] = v[23:19];
         sa0[v[26:24]] = v[18:14];
         run(0, cyc, serr, smsg);
         if (serr != 0) $display("FAIL R2 R3 R4 R5 R10 sequence %s", smsg);
         check(serr == 0, "R2 R3 R4 R5 R10 op sequence", serr, 0);
         check(cyc == 13 * N + 1, "R6 done timing", cyc, 13 * N + 1);
         check(fail == v[13], "R7 R9 fail flag", int'(fail), int'(v[13]));
         if (v[13]) begin
            check(f_addr == v[12:10], "R7 fail address", int'(f_addr), int'(v[12:10]));
            check(f_exp == v[9:5], "R7 expected code", int'(f_exp), int'(v[9:5]));
            check(f_obs == v[4:0], "R7 observed code", int'(f_obs), int'(v[4:0]));
         end
         @(negedge clk);
         check(!done && !busy, "R6 done single pulse", {done, busy}, 0);
      end

      // R7: two faults; the earlier-detected one is kept, not the lower address
      clear_faults();
      sa0[2] = 5'b01000;
      sa1[6] = 5'b00001;
      run(0, cyc, serr, smsg);
      check(fail == 1'b1, "R7 multi fault flag", int'(fail), 1);
      check(f_addr == 3'd6, "R7 first mismatch address", int'(f_addr), 6);
      check(f_exp == 5'b00000 && f_obs == 5'b00001, "R7 first mismatch codes",
            int'({f_exp, f_obs}), int'({5'b00000, 5'b00001}));
      @(negedge clk);

      // R8: start pulses mid-run do not disturb sequence or timing
      clear_faults();
      run(N + 3, cyc, serr, smsg);
      if (serr != 0) $display("FAIL R8 sequence %s", smsg);
      check(serr == 0, "R8 sequence with mid-run start", serr, 0);
      check(cyc == 13 * N + 1, "R8 done timing with mid-run start", cyc, 13 * N + 1);
      check(!fail, "R8 no fail", int'(fail), 0);
      @(negedge clk);
      check(!busy && !we && !re, "R8 idle after run", {busy, we, re}, 0);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule